// File: doc/BRIEF.md
# Load-Store Byte Lane Aligner

This block sits between a 32-bit core and a byte-addressed, little-endian data port that is one word wide. On the store side it takes an effective byte address, an access size and the store operand. In the same cycle it produces the word-aligned bus address, write data with the operand copied into every lane it may occupy, and one write strobe per byte lane. On the load side it captures the low address bits, the size and the signedness when the request is accepted. When the returned word arrives, it extracts the addressed byte or halfword and extends it to the full word width.

Accesses whose address is not a multiple of their size raise a misaligned flag. Such an access produces no write strobes, and a misaligned load is never captured. The load context is held by a two-state machine. `ST_IDLE` accepts an aligned load request and moves to `ST_WAIT` (transition *capture*). `ST_WAIT` holds the context until `rsp_valid` arrives and then returns to `ST_IDLE` (transition *retire*). In every other case each state stays where it is. The memory, the bus handshake and trap handling belong to the surrounding logic.

Size encoding on `req_size`: `2'b00` byte, `2'b01` halfword, `2'b10` word. `2'b11` is treated as a word.

Top module: `lsu_lane_align`

## Requirements
- R1: `bus_addr` equals `req_addr` with its two low bits forced to zero, combinationally.
- R2: For a byte write request at offset k = `req_addr[1:0]`, `bus_wdata` carries `req_wdata[7:0]` in all four lanes, and `bus_strb` is `1 << k`.
- R3: For an aligned halfword write request, `bus_wdata` is `{req_wdata[15:0], req_wdata[15:0]}`. `bus_strb` is `4'b0011` at offset 0 and `4'b1100` at offset 2.
- R4: For an aligned word write request, `bus_wdata` equals `req_wdata` and `bus_strb` is `4'b1111`.
- R5: `misaligned` is 1 while `req_valid` is high and the request is either a halfword with `req_addr[0]` = 1 or a word with `req_addr[1:0]` ≠ 0. In that case `bus_strb` is `4'b0000`, and a load is not captured. `bus_strb` is also zero whenever no write is requested.
- R6: An aligned load request (`req_valid`=1, `req_write`=0) seen in `ST_IDLE` sets `load_pending` from the next cycle.
- R7: When `rsp_valid` is high while `load_pending` is set, `ld_valid` is 1 in the following cycle only, and `load_pending` is 0 from that cycle.
- R8: A word load returns `rsp_rdata` unchanged: the byte at the address is in bits 7:0 and the byte at address+3 is in bits 31:24.
- R9: A halfword load takes `rsp_rdata[15:0]` at offset 0 or `rsp_rdata[31:16]` at offset 2. Bits 31:16 are filled with bit 15 of the halfword when signed (`req_unsigned`=0) and with zeros when unsigned.
- R10: A byte load takes the lane at the captured offset. Bits 31:8 are filled with bit 7 of that byte when signed and with zeros when unsigned.
- R11: Requests made while `load_pending` is set do not change the captured context, and `rsp_valid` in `ST_IDLE` leaves `ld_valid` at 0.
- R12: After reset, `load_pending`, `ld_valid` and `ld_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 store, 0 load |
| req_addr | input | 32 | Effective byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Load zero-extends when 1 |
| req_wdata | input | 32 | Store operand, low-order bytes used first |
| bus_addr | output | 32 | Word-aligned address |
| bus_wdata | output | 32 | Lane-replicated write data |
| bus_strb | output | 4 | Byte write strobes, bit i for lane i |
| misaligned | output | 1 | Current request is misaligned |
| load_pending | output | 1 | Load context held, awaiting response |
| rsp_valid | input | 1 | Read response present |
| rsp_rdata | input | 32 | Returned word |
| ld_valid | output | 1 | One-cycle pulse, `ld_data` valid |
| ld_data | output | 32 | Extracted and extended load result |

## Verification
The hardest situation to reach from the ports is a second request that collides with an outstanding load. The captured offset, size and sign must survive it, and that can only be seen through the result of the first load. The stimulus issues a signed byte load at offset 3, keeps a conflicting unsigned halfword load asserted while waiting, and then returns a word whose lane 3 has its top bit set. With the stray request left in force, only the original context produces the sign-filled result. A response offered in the idle state is likewise checked to raise no result pulse.

// File: rtl/lane_pkg.sv
package lane_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ld_state_e;

    // number of bytes an access of the given size touches, capped to the lane count
    function automatic int unsigned size_bytes(input logic [1:0] sz, input int unsigned lanes);
        int unsigned n;
        unique case (sz)
            SZ_BYTE: n = 1;
            SZ_HALF: n = 2;
            default: n = 4;
        endcase
        if (n > lanes) n = lanes;
        return n;
    endfunction
endpackage

// File: rtl/lane_store_gen.sv
module lane_store_gen
    import lane_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  logic              is_write_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              misalign_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic [LANES-1:0]  strb_o
);
    logic [OFF_W-1:0] size_mask;
    logic [LANES-1:0] base_mask;

    always_comb begin
        base_mask = '0;
        size_mask = '0;
        unique case (size_i)
            SZ_BYTE: begin
                base_mask = LANES'(1);
                size_mask = '0;
            end
            SZ_HALF: begin
                base_mask = LANES'(3);
                size_mask = OFF_W'(1);
            end
            default: begin
                base_mask = '1;
                size_mask = '1;
            end
        endcase
    end

    assign misalign_o = |(off_i & size_mask);

    always_comb begin
        if (is_write_i && !misalign_o)
            strb_o = base_mask << off_i;
        else
            strb_o = '0;
    end

    // each lane carries the operand byte that lands there for any legal offset
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            unique case (size_i)
                SZ_BYTE: bus_wdata_o[g*8 +: 8] = wdata_i[7:0];
                SZ_HALF: bus_wdata_o[g*8 +: 8] = wdata_i[(g % 2)*8 +: 8];
                default: bus_wdata_o[g*8 +: 8] = wdata_i[g*8 +: 8];
            endcase
        end
    end
endmodule

// File: rtl/lane_load_ext.sv
module lane_load_ext
    import lane_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [1:0]        size_i,
    input  logic              uns_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] shifted;
    logic              fill;

    assign shifted = rdata_i >> {off_i, 3'b000};

    always_comb begin
        fill   = 1'b0;
        data_o = shifted;
        unique case (size_i)
            SZ_BYTE: begin
                fill   = !uns_i && shifted[7];
                data_o = {{(DATA_W-8){fill}}, shifted[7:0]};
            end
            SZ_HALF: begin
                fill   = !uns_i && shifted[15];
                data_o = {{(DATA_W-16){fill}}, shifted[15:0]};
            end
            default: begin
                data_o = shifted;
            end
        endcase
    end
endmodule

// File: rtl/lane_load_ctx.sv
module lane_load_ctx
    import lane_pkg::*;
#(
    parameter int unsigned OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_req_i,
    input  logic             rsp_valid_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [1:0]       size_i,
    input  logic             uns_i,
    output logic             pending_o,
    output logic             retire_o,
    output logic [OFF_W-1:0] ctx_off_o,
    output logic [1:0]       ctx_size_o,
    output logic             ctx_uns_o
);
    ld_state_e state_q, state_d;
    logic      capture;

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (load_req_i) begin
                    state_d = ST_WAIT;
                    capture = 1'b1;
                end
            end
            ST_WAIT: begin
                if (rsp_valid_i) state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_off_o  <= '0;
            ctx_size_o <= SZ_BYTE;
            ctx_uns_o  <= 1'b0;
        end else if (capture) begin
            ctx_off_o  <= off_i;
            ctx_size_o <= size_i;
            ctx_uns_o  <= uns_i;
        end
    end

    assign pending_o = (state_q == ST_WAIT);
    assign retire_o  = (state_q == ST_WAIT) && rsp_valid_i;
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lane_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [LANES-1:0]  bus_strb,
    output logic              misaligned,
    output logic              load_pending,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data
);
    logic [OFF_W-1:0]  off;
    logic              mis_raw;
    logic              retire;
    logic [OFF_W-1:0]  ctx_off;
    logic [1:0]        ctx_size;
    logic              ctx_uns;
    logic [DATA_W-1:0] ext_data;

    assign off        = req_addr[OFF_W-1:0];
    assign bus_addr   = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign misaligned = req_valid && mis_raw;

    lane_store_gen #(.DATA_W(DATA_W)) u_store (
        .is_write_i  (req_valid && req_write),
        .off_i       (off),
        .size_i      (req_size),
        .wdata_i     (req_wdata),
        .misalign_o  (mis_raw),
        .bus_wdata_o (bus_wdata),
        .strb_o      (bus_strb)
    );

    lane_load_ctx #(.OFF_W(OFF_W)) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_req_i  (req_valid && !req_write && !mis_raw),
        .rsp_valid_i (rsp_valid),
        .off_i       (off),
        .size_i      (req_size),
        .uns_i       (req_unsigned),
        .pending_o   (load_pending),
        .retire_o    (retire),
        .ctx_off_o   (ctx_off),
        .ctx_size_o  (ctx_size),
        .ctx_uns_o   (ctx_uns)
    );

    lane_load_ext #(.DATA_W(DATA_W)) u_ext (
        .rdata_i (rsp_rdata),
        .off_i   (ctx_off),
        .size_i  (ctx_size),
        .uns_i   (ctx_uns),
        .data_o  (ext_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ld_data  <= '0;
        end else begin
            ld_valid <= retire;
            if (retire) ld_data <= ext_data;
        end
    end
endmodule

// File: rtl/lane_align_chk.sv
module lane_align_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [LANES-1:0]  bus_strb,
    input logic              misaligned,
    input logic              load_pending,
    input logic              rsp_valid,
    input logic              ld_valid
);
    // R1
    addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[1:0] == 2'b00);

    // R5
    mis_no_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> bus_strb == '0);

    // R2
    byte_one_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size == 2'b00) |-> $countones(bus_strb) == 1);

    // R5
    idle_no_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |-> bus_strb == '0);

    // R7
    result_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pending && rsp_valid) |=> (ld_valid && !load_pending));

    // R7
    result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !ld_valid);

    // R6
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_pending && req_valid && !req_write && !misaligned) |=> load_pending);

    // R11
    idle_rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_pending && rsp_valid) |=> !ld_valid);
endmodule

bind lsu_lane_align lane_align_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_size     (req_size),
    .bus_addr     (bus_addr),
    .bus_strb     (bus_strb),
    .misaligned   (misaligned),
    .load_pending (load_pending),
    .rsp_valid    (rsp_valid),
    .ld_valid     (ld_valid)
);

// File: tb/sim_lsu_lane_align.sv
module sim_lsu_lane_align;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_strb;
    logic        misaligned;
    logic        load_pending;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_rdata = '0;
    logic        ld_valid;
    logic [31:0] ld_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lsu_lane_align u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_unsigned(req_unsigned),
        .req_wdata(req_wdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_strb(bus_strb), .misaligned(misaligned), .load_pending(load_pending),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        req_valid = 0; req_write = 0; rsp_valid = 0;
    endtask

    task automatic drive_store(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_size = sz; req_wdata = d;
        #1;
    endtask

    // full load transaction; checks result pulse and data
    task automatic run_load(input string req, input logic [31:0] a, input logic [1:0] sz,
                            input logic uns, input logic [31:0] rd, input logic [31:0] exp);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_size = sz; req_unsigned = uns;
        @(negedge clk);
        idle_bus();
        check("R6 pending", {31'b0, load_pending}, 32'd1);
        rsp_valid = 1; rsp_rdata = rd;
        @(negedge clk);
        rsp_valid = 0;
        check("R7 ld_valid", {31'b0, ld_valid}, 32'd1);
        check("R7 pending cleared", {31'b0, load_pending}, 32'd0);
        check(req, ld_data, exp);
        @(negedge clk);
        check("R7 single pulse", {31'b0, ld_valid}, 32'd0);
    endtask

    task automatic t_reset();
        check("R12 pending", {31'b0, load_pending}, 32'd0);
        check("R12 ld_valid", {31'b0, ld_valid}, 32'd0);
        check("R12 ld_data", ld_data, 32'd0);
    endtask

    task automatic t_store_byte();
        for (int k = 0; k < 4; k++) begin
            drive_store(32'h1000_0010 + k, 2'b00, 32'hDEAD_BEA5 + k);
            check("R1 addr", bus_addr, 32'h1000_0010);
            check("R2 wdata", bus_wdata, {4{8'(8'hA5 + k)}});
            check("R2 strb", {28'b0, bus_strb}, 32'(4'b0001 << k));
            check("R5 mis", {31'b0, misaligned}, 32'd0);
        end
        idle_bus();
    endtask

    task automatic t_store_half();
        drive_store(32'h2000_0000, 2'b01, 32'hFFFF_1234);
        check("R3 wdata", bus_wdata, 32'h1234_1234);
        check("R3 strb lo", {28'b0, bus_strb}, 32'h3);
        drive_store(32'h2000_0006, 2'b01, 32'h0000_ABCD);
        check("R1 addr", bus_addr, 32'h2000_0004);
        check("R3 strb hi", {28'b0, bus_strb}, 32'hC);
        idle_bus();
    endtask

    task automatic t_store_word();
        drive_store(32'h3000_0008, 2'b10, 32'h8765_4321);
        check("R4 wdata", bus_wdata, 32'h8765_4321);
        check("R4 strb", {28'b0, bus_strb}, 32'hF);
        drive_store(32'h3000_0008, 2'b10, 32'h8765_4321);
        req_valid = 0;
        #1;
        check("R5 no request strb", {28'b0, bus_strb}, 32'h0);
        idle_bus();
    endtask

    task automatic t_misaligned();
        drive_store(32'h4000_0001, 2'b01, 32'h1111_2222);
        check("R5 half odd mis", {31'b0, misaligned}, 32'd1);
        check("R5 half odd strb", {28'b0, bus_strb}, 32'h0);
        drive_store(32'h4000_0003, 2'b01, 32'h1111_2222);
        check("R5 half off3 mis", {31'b0, misaligned}, 32'd1);
        drive_store(32'h4000_0002, 2'b10, 32'h1111_2222);
        check("R5 word off2 mis", {31'b0, misaligned}, 32'd1);
        check("R5 word off2 strb", {28'b0, bus_strb}, 32'h0);
        // misaligned load must not be captured
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 32'h4000_0001; req_size = 2'b10;
        #1;
        check("R5 load mis", {31'b0, misaligned}, 32'd1);
        @(negedge clk);
        idle_bus();
        check("R5 load not captured", {31'b0, load_pending}, 32'd0);
    endtask

    task automatic t_load_word();
        run_load("R8 word", 32'h5000_0000, 2'b10, 1'b0, 32'h8899_AABB, 32'h8899_AABB);
    endtask

    task automatic t_load_half();
        run_load("R9 half lo signed", 32'h5000_0000, 2'b01, 1'b0, 32'h1234_8001, 32'hFFFF_8001);
        run_load("R9 half hi signed", 32'h5000_0002, 2'b01, 1'b0, 32'hF00D_0001, 32'hFFFF_F00D);
        run_load("R9 half hi unsigned", 32'h5000_0002, 2'b01, 1'b1, 32'hF00D_0001, 32'h0000_F00D);
        run_load("R9 half lo positive", 32'h5000_0000, 2'b01, 1'b0, 32'hFFFF_7FFE, 32'h0000_7FFE);
    endtask

    task automatic t_load_byte();
        for (int k = 0; k < 4; k++) begin
            run_load("R10 byte signed", 32'h6000_0000 + k, 2'b00, 1'b0, 32'h8011_9022 << 0,
                     (k == 0) ? 32'h0000_0022 : (k == 1) ? 32'hFFFF_FF90 :
                     (k == 2) ? 32'h0000_0011 : 32'hFFFF_FF80);
        end
        run_load("R10 byte unsigned", 32'h6000_0003, 2'b00, 1'b1, 32'h8011_9022, 32'h0000_0080);
    endtask

    task automatic t_collide();
        // response while idle gives no result
        @(negedge clk);
        rsp_valid = 1; rsp_rdata = 32'hFFFF_FFFF;
        @(negedge clk);
        rsp_valid = 0;
        check("R11 idle rsp", {31'b0, ld_valid}, 32'd0);
        // signed byte load at offset 3, then a conflicting request held while waiting
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 32'h7000_0003; req_size = 2'b00; req_unsigned = 0;
        @(negedge clk);
        req_addr = 32'h7000_0000; req_size = 2'b01; req_unsigned = 1;
        @(negedge clk);
        check("R11 still pending", {31'b0, load_pending}, 32'd1);
        rsp_valid = 1; rsp_rdata = 32'hC3_00_7F_55;
        @(negedge clk);
        idle_bus();
        check("R11 ld_valid", {31'b0, ld_valid}, 32'd1);
        check("R11 context kept", ld_data, 32'hFFFF_FFC3);
        @(negedge clk);
    endtask

    initial begin
        #1;
        t_reset();
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_store_byte();
        t_store_half();
        t_store_word();
        t_misaligned();
        t_load_word();
        t_load_half();
        t_load_byte();
        t_collide();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule